// File: doc/BRIEF.md
# LUT-Based Logic Element

A single configurable logic element: a 4-input look-up table whose 16 configuration bits define any function of its inputs, followed by a programmable single-bit register. The register can behave as a D, T, JK or SR flip-flop, has a synchronous enable, and takes an asynchronous clear, preset or load from two control lines. A ripple carry chain and an AND cascade chain let neighbouring elements be joined into adders, counters and wide AND functions.

Four modes decide where seven internal signals go: the four data inputs, the register feedback, carry-in and cascade-in. Normal mode indexes the table with all four data bits. Arithmetic mode forms a sum bit through the table and a majority carry. The two counter modes drive the register from counter logic, with a direction and a load input, or with a synchronous clear input. The element has two outputs, local and global, and each one is set on its own to show the combinational result or the register. The table can then drive one net while the register drives another.

Top module: `lut_logic_element`

## Requirements
- R1: In normal mode (cfg_mode_i=0) the combinational result is cfg_table_i[data_i], with data_i[3] as the index MSB. The local or global output shows it when that output's register select is 0. With the cascade gate off, cascade_o equals this result.
- R2: local_o shows the register when cfg_local_reg_i=1, and global_o does the same when cfg_global_reg_i=1. Each choice is independent of the other. With cfg_bypass_i=1 both outputs show the combinational result.
- R3: In normal and arithmetic modes, with ena_i=1, the register updates at the rising clock edge. Let S be the combinational result and K be data_i[3]. The type cfg_ff_i selects the rule: 0=D (q<=S), 1=T (q<=q^S), 2=JK (J=S, K: 00 hold, 10 set, 01 clear, 11 toggle), 3=SR (S sets, K clears, clear wins, 00 holds).
- R4: With ena_i=0 and no asynchronous control active, the register holds in every mode.
- R5: In arithmetic mode (1) the table index is {0, carry_i, data_i[1], data_i[0]}. carry_o is the majority of data_i[0], data_i[1] and carry_i. In normal mode carry_o=0.
- R6: With cfg_casc_en_i=1 the combinational result is the table bit ANDed with cascade_i, in every mode, and cascade_o carries this result.
- R7: In up/down counter mode (2), data_i[3]=1 loads data_i[0] into the register. Otherwise the register gets q^carry_i. carry_o=carry_i&q when data_i[2]=1 (up) and carry_i&~q when data_i[2]=0 (down). The table is indexed as in normal mode.
- R8: In clearable counter mode (3), data_i[2]=1 clears the register at the edge. Otherwise the register gets q^carry_i, and carry_o=carry_i&q.
- R9: With cfg_actl_i=1 the selected line (ctl_i[0] if cfg_clr_sel_i=0, ctl_i[1] if 1) clears the register at once and keeps it at 0 while high. The other line has no effect.
- R10: With cfg_actl_i=2 the selected line presets the register to 1 at once and keeps it at 1 while high.
- R11: With cfg_actl_i=3 a rising ctl_i[0] loads data_i[2] into the register at once. While ctl_i[0] stays high, data_i[2] is loaded again at each clock edge. With cfg_actl_i=0 the control lines are ignored.
- R12: rst_ni low clears the register asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | LUT_INPUTS (4) | Data inputs, table index |
| carry_i | input | 1 | Carry chain input |
| cascade_i | input | 1 | Cascade chain input |
| ena_i | input | 1 | Synchronous register enable |
| ctl_i | input | 2 | Control lines for asynchronous clear, preset or load |
| cfg_table_i | input | 2**LUT_INPUTS (16) | Table contents |
| cfg_mode_i | input | 2 | 0 normal, 1 arithmetic, 2 up/down counter, 3 clearable counter |
| cfg_ff_i | input | 2 | Register type: 0 D, 1 T, 2 JK, 3 SR |
| cfg_actl_i | input | 2 | Asynchronous action: 0 none, 1 clear, 2 preset, 3 load |
| cfg_clr_sel_i | input | 1 | Control line used for clear or preset |
| cfg_bypass_i | input | 1 | Send the combinational result to both outputs |
| cfg_local_reg_i | input | 1 | local_o shows the register |
| cfg_global_reg_i | input | 1 | global_o shows the register |
| cfg_casc_en_i | input | 1 | AND the table bit with cascade_i |
| local_o | output | 1 | Local output |
| global_o | output | 1 | Global output |
| carry_o | output | 1 | Carry chain output |
| cascade_o | output | 1 | Cascade chain output |

## Verification
The assertions check the following on every cycle: a register held with the enable low, clear and preset dominating, the value captured on a rising load line, the synchronous clear and load of the counters, cascade blocking, the absence of carry in normal mode, and equal outputs under bypass. The full table lookup, the four register types, the counter carry rules and the independence of the two output selects are shown only by the bench's scenarios. These run random configurations against a cycle model and add directed sequences for counting, async load hold and reset.

// File: rtl/le_pkg.sv
package le_pkg;
  typedef enum logic [1:0] {MODE_NORMAL, MODE_ARITH, MODE_UPDN, MODE_CLRCNT} le_mode_e;
  typedef enum logic [1:0] {FF_D, FF_T, FF_JK, FF_SR} ff_kind_e;
  typedef enum logic [1:0] {ACTL_NONE, ACTL_CLEAR, ACTL_PRESET, ACTL_LOAD} actl_e;
endpackage

// File: rtl/le_lut.sv
module le_lut #(
  parameter int unsigned N = 4,
  localparam int unsigned TBL = 1 << N
) (
  input  logic [TBL-1:0] table_i,
  input  logic [N-1:0]   sel_i,
  output logic           bit_o
);
  assign bit_o = table_i[sel_i];
endmodule

// File: rtl/le_steer.sv
module le_steer import le_pkg::*; #(
  parameter int unsigned N = 4,
  localparam int unsigned TBL = 1 << N
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  le_mode_e       mode_i,
  input  logic [N-1:0]   d_i,
  input  logic           q_i,
  input  logic           carry_i,
  input  logic           cascade_i,
  input  logic           casc_en_i,
  input  logic [TBL-1:0] table_i,
  output logic           comb_o,
  output logic           carry_o,
  output logic           cascade_o,
  output logic           cnt_mode_o,
  output logic           cnt_next_o
);
  logic [N-1:0] idx;
  logic         lut_bit;

  always_comb begin
    idx = d_i;
    if (mode_i == MODE_ARITH) begin
      idx      = '0;
      idx[2:0] = {carry_i, d_i[1], d_i[0]};
    end
  end

  le_lut #(.N(N)) u_lut (.table_i(table_i), .sel_i(idx), .bit_o(lut_bit));

  assign comb_o    = lut_bit & (~casc_en_i | cascade_i);
  assign cascade_o = comb_o;

  always_comb begin
    unique case (mode_i)
      MODE_ARITH:  carry_o = (d_i[0] & d_i[1]) | (carry_i & (d_i[0] | d_i[1]));
      MODE_UPDN:   carry_o = carry_i & (d_i[2] ? q_i : ~q_i);
      MODE_CLRCNT: carry_o = carry_i & q_i;
      default:     carry_o = 1'b0;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      MODE_UPDN:   cnt_next_o = d_i[3] ? d_i[0] : (q_i ^ carry_i);
      MODE_CLRCNT: cnt_next_o = d_i[2] ? 1'b0 : (q_i ^ carry_i);
      default:     cnt_next_o = q_i;
    endcase
  end

  assign cnt_mode_o = (mode_i == MODE_UPDN) || (mode_i == MODE_CLRCNT);

  // R6
  a_r6_cascade_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (casc_en_i && !cascade_i) |-> !cascade_o);
  // R5
  a_r5_normal_no_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_NORMAL) |-> !carry_o);
endmodule

// File: rtl/le_reg.sv
module le_reg import le_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ena_i,
  input  ff_kind_e   ff_kind_i,
  input  logic       cnt_mode_i,
  input  logic       cnt_next_i,
  input  logic       set_in_i,
  input  logic       clr_in_i,
  input  actl_e      actl_i,
  input  logic       clr_sel_i,
  input  logic [1:0] ctl_i,
  input  logic       ld_data_i,
  output logic       q_o
);
  logic line, clr_act, pre_act, ld_act, async_any, d_next;

  assign line      = clr_sel_i ? ctl_i[1] : ctl_i[0];
  assign clr_act   = (actl_i == ACTL_CLEAR)  && line;
  assign pre_act   = (actl_i == ACTL_PRESET) && line;
  assign ld_act    = (actl_i == ACTL_LOAD)   && ctl_i[0];
  assign async_any = clr_act | pre_act | ld_act;

  always_comb begin
    if (cnt_mode_i) d_next = cnt_next_i;
    else begin
      unique case (ff_kind_i)
        FF_D:  d_next = set_in_i;
        FF_T:  d_next = q_o ^ set_in_i;
        FF_JK: begin
          unique case ({set_in_i, clr_in_i})
            2'b10:   d_next = 1'b1;
            2'b01:   d_next = 1'b0;
            2'b11:   d_next = ~q_o;
            default: d_next = q_o;
          endcase
        end
        default: d_next = clr_in_i ? 1'b0 : (set_in_i | q_o);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni or posedge async_any) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (clr_act) q_o <= 1'b0;
    else if (pre_act) q_o <= 1'b1;
    else if (ld_act)  q_o <= ld_data_i;
    else if (ena_i)   q_o <= d_next;
  end

  // R4
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ena_i && !async_any) |=> (async_any || $stable(q_o)));
  // R9
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_act |-> !q_o);
  // R10
  a_r10_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_act |-> q_o);
  // R11
  a_r11_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_act) |-> (q_o == ld_data_i));
endmodule

// File: rtl/lut_logic_element.sv
module lut_logic_element import le_pkg::*; #(
  parameter int unsigned LUT_INPUTS = 4,
  localparam int unsigned TBL = 1 << LUT_INPUTS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [LUT_INPUTS-1:0] data_i,
  input  logic                  carry_i,
  input  logic                  cascade_i,
  input  logic                  ena_i,
  input  logic [1:0]            ctl_i,
  input  logic [TBL-1:0]        cfg_table_i,
  input  logic [1:0]            cfg_mode_i,
  input  logic [1:0]            cfg_ff_i,
  input  logic [1:0]            cfg_actl_i,
  input  logic                  cfg_clr_sel_i,
  input  logic                  cfg_bypass_i,
  input  logic                  cfg_local_reg_i,
  input  logic                  cfg_global_reg_i,
  input  logic                  cfg_casc_en_i,
  output logic                  local_o,
  output logic                  global_o,
  output logic                  carry_o,
  output logic                  cascade_o
);
  le_mode_e mode;
  logic     comb, q, cnt_mode, cnt_next;

  assign mode = le_mode_e'(cfg_mode_i);

  le_steer #(.N(LUT_INPUTS)) u_steer (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .d_i(data_i), .q_i(q),
    .carry_i(carry_i), .cascade_i(cascade_i), .casc_en_i(cfg_casc_en_i),
    .table_i(cfg_table_i), .comb_o(comb), .carry_o(carry_o),
    .cascade_o(cascade_o), .cnt_mode_o(cnt_mode), .cnt_next_o(cnt_next)
  );

  le_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ena_i(ena_i), .ff_kind_i(ff_kind_e'(cfg_ff_i)),
    .cnt_mode_i(cnt_mode), .cnt_next_i(cnt_next), .set_in_i(comb),
    .clr_in_i(data_i[3]), .actl_i(actl_e'(cfg_actl_i)), .clr_sel_i(cfg_clr_sel_i),
    .ctl_i(ctl_i), .ld_data_i(data_i[2]), .q_o(q)
  );

  assign local_o  = (cfg_local_reg_i  && !cfg_bypass_i) ? q : comb;
  assign global_o = (cfg_global_reg_i && !cfg_bypass_i) ? q : comb;

  // R2
  a_r2_bypass_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bypass_i |-> (local_o == global_o));
  // R8
  a_r8_sync_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_actl_i == 2'd0 && mode == MODE_CLRCNT && ena_i && data_i[2])
      |=> (!q || cfg_actl_i != 2'd0));
  // R7
  a_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_actl_i == 2'd0 && mode == MODE_UPDN && ena_i && data_i[3])
      |=> (q == $past(data_i[0]) || cfg_actl_i != 2'd0));
endmodule

// File: tb/lut_logic_element_tb_top.sv
module lut_logic_element_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] d = '0;
  logic carry_in = 0, casc_in = 0, ena = 0;
  logic [1:0] ctl = '0;
  logic [15:0] lut = '0;
  logic [1:0] mode = '0, ff = '0, actl = '0;
  logic clr_sel = 0, bypass = 0, loc_sel = 0, glb_sel = 0, casc_en = 0;
  logic local_o, global_o, carry_o, cascade_o;
  logic mq = 1'b0;
  logic prev_act = 1'b0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lut_logic_element dut_i (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d), .carry_i(carry_in), .cascade_i(casc_in),
    .ena_i(ena), .ctl_i(ctl), .cfg_table_i(lut), .cfg_mode_i(mode), .cfg_ff_i(ff),
    .cfg_actl_i(actl), .cfg_clr_sel_i(clr_sel), .cfg_bypass_i(bypass),
    .cfg_local_reg_i(loc_sel), .cfg_global_reg_i(glb_sel), .cfg_casc_en_i(casc_en),
    .local_o(local_o), .global_o(global_o), .carry_o(carry_o), .cascade_o(cascade_o)
  );

  function automatic logic comb_f();
    logic [3:0] idx = (mode == 2'd1) ? {1'b0, carry_in, d[1], d[0]} : d;
    return lut[idx] & (casc_en ? casc_in : 1'b1);
  endfunction

  function automatic logic carry_f();
    case (mode)
      2'd1: return (d[0] & d[1]) | (d[0] & carry_in) | (d[1] & carry_in);
      2'd2: return carry_in & (d[2] ? mq : ~mq);
      2'd3: return carry_in & mq;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic next_f(input logic s);
    if (mode == 2'd2) return d[3] ? d[0] : (mq ^ carry_in);
    if (mode == 2'd3) return d[2] ? 1'b0 : (mq ^ carry_in);
    case (ff)
      2'd0: return s;
      2'd1: return mq ^ s;
      2'd2: case ({s, d[3]}) 2'b10: return 1'b1; 2'b01: return 1'b0;
              2'b11: return ~mq; default: return mq; endcase
      default: return d[3] ? 1'b0 : (s ? 1'b1 : mq);
    endcase
  endfunction

  function automatic logic act_f();
    logic line = clr_sel ? ctl[1] : ctl[0];
    return ((actl == 2'd1 || actl == 2'd2) && line) || (actl == 2'd3 && ctl[0]);
  endfunction

  function automatic logic async_val();
    if (actl == 2'd1) return 1'b0;
    if (actl == 2'd2) return 1'b1;
    return d[2];
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: {local,global,carry,cascade} got=%b exp=%b", tag, got, exp);
    end
  endtask

  // inputs are set at a falling edge before the call
  task automatic cyc(input string tag);
    logic s;
    logic [3:0] exp;
    #1;
    if (act_f() && !prev_act) mq = async_val();
    prev_act = act_f();
    s = comb_f();
    exp = {(bypass || !loc_sel) ? s : mq, (bypass || !glb_sel) ? s : mq, carry_f(), s};
    check(tag, {local_o, global_o, carry_o, cascade_o}, exp);
    @(posedge clk);
    if (act_f()) mq = async_val();
    else if (ena) mq = next_f(s);
    prev_act = act_f();
    @(negedge clk);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12: reset value seen through both register selects
    loc_sel = 1; glb_sel = 1;
    cyc("R12");
    // R1/R3 normal mode, all register types, random
    for (int i = 0; i < 400; i++) begin
      if (i % 40 == 0) lut = 16'($urandom);
      {d, carry_in, casc_in} = 6'($urandom);
      ena = 1'($urandom); ctl = 2'($urandom);
      ff = 2'($urandom);
      mode = (i < 200) ? 2'd0 : 2'($urandom);
      {bypass, loc_sel, glb_sel, casc_en} = 4'($urandom);
      if (i % 4 == 0) bypass = 0;
      cyc(mode == 2'd0 ? "R1 R3" : mode == 2'd1 ? "R5 R3" : mode == 2'd2 ? "R7" : "R8");
    end
    // R2: independent selects, table = d0
    lut = 16'hAAAA; mode = 0; ff = 0; casc_en = 0; bypass = 0; ena = 1;
    d = 4'b0001; loc_sel = 0; glb_sel = 0; cyc("R2");
    d = 4'b0000; loc_sel = 1; glb_sel = 0; cyc("R2");
    loc_sel = 0; glb_sel = 1; d = 4'b0001; cyc("R2");
    bypass = 1; cyc("R2");
    bypass = 0;
    // R3 JK toggle and SR clear dominance
    ff = 2; d = 4'b1001; cyc("R3"); cyc("R3");
    ff = 3; d = 4'b1001; cyc("R3");
    // R4 hold with enable low, normal and counter mode
    ena = 0; ff = 0; loc_sel = 1; d = 4'b0001; cyc("R4"); cyc("R4");
    mode = 3; carry_in = 1; d = 0; cyc("R4");
    ena = 1;
    // R5 arithmetic exhaustive, parity table
    mode = 1; lut = 16'h0096;
    for (int v = 0; v < 8; v++) begin
      d = {2'b00, 2'(v)}; carry_in = v[2]; cyc("R5");
    end
    // R6 cascade gate
    mode = 0; lut = 16'hFFFF; casc_en = 1; casc_in = 0; cyc("R6");
    casc_in = 1; cyc("R6");
    casc_en = 0;
    // R7 up/down counter: load, count up, count down
    mode = 2; d = 4'b1001; cyc("R7");
    d = 4'b0100; carry_in = 1; cyc("R7"); cyc("R7");
    d = 4'b0000; cyc("R7"); cyc("R7");
    carry_in = 0; cyc("R7");
    // R8 clearable counter
    mode = 3; d = 4'b0000; carry_in = 1; cyc("R8");
    d = 4'b0100; cyc("R8"); cyc("R8");
    // R9 async clear on ctl[1], ctl[0] ignored
    mode = 0; ff = 0; lut = 16'hFFFF; ena = 1; cyc("R9");
    actl = 1; clr_sel = 1; ctl = 2'b01; cyc("R9");
    ctl = 2'b10; cyc("R9"); cyc("R9");
    ctl = 2'b00; cyc("R9");
    // R10 async preset on ctl[0]
    lut = 16'h0000; actl = 2; clr_sel = 0;
    cyc("R10");
    ctl = 2'b01; cyc("R10"); cyc("R10");
    ctl = 2'b00; cyc("R10");
    // R11 async load of d[2], held across edges
    actl = 3; lut = 16'hFFFF; d = 4'b0000; cyc("R11");
    ctl = 2'b01; d = 4'b0000; cyc("R11"); cyc("R11");
    ctl = 2'b00; cyc("R11");
    lut = 16'h0000; cyc("R11");
    ctl = 2'b01; d = 4'b0100; cyc("R11");
    ctl = 2'b00; actl = 0; cyc("R11");
    ctl = 2'b11; cyc("R11");
    ctl = 2'b00;
    // R12 reset mid-run
    lut = 16'hFFFF; cyc("R12");
    rst_n = 0; mq = 0; ena = 0; cyc("R12");
    rst_n = 1; cyc("R12");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule